// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block maps a 16-bit virtual address to a 15-bit physical address through a page table of sixteen entries kept entirely in flip-flops. The top four address bits select an entry; each entry records whether the page is resident, which of eight frames holds it, and whether the page has been used or written since software last cleared those marks. The low twelve bits are the byte offset inside a 4 KB page and pass straight through.

A requester presents an address with a write flag. One clock later the block returns either a translated physical address or a fault indication. Every access to a resident page sets that entry's usage mark, and a write access also sets the dirty mark. System software fills or rewrites entries through a load port, reads any entry back through a combinational inspection port, and can wipe all usage marks at once for periodic ageing.

Top module: `pgxl_translator`

## Requirements
- R1: The page index is req_addr[15:12] and the byte offset is req_addr[11:0], so a page spans 4096 bytes.
- R2: On an access to a resident page, rsp_paddr = {frame, offset}, with the frame in bits 14:12; address 8196 with entry 2 holding frame 6 gives 24580.
- R3: rsp_valid and rsp_fault are registered: they reflect the request accepted at the previous clock edge, and both are 0 in the cycle after a cycle with req_valid low.
- R4: When ld_en is 1, entry ld_idx takes ld_frame, ld_present, ld_ref and ld_mod at the next clock edge.
- R5: An access to an entry whose present bit is 0 gives rsp_fault=1, rsp_valid=0 and rsp_paddr=0.
- R6: Any access to a resident page sets that entry's referenced bit; a faulting access changes no bit of the entry.
- R7: A write access (req_write=1) to a resident page sets its modified bit; a read access leaves the modified bit as it was.
- R8: If a load and a hardware usage update hit the same entry in one cycle, the entry ends holding exactly the loaded value; the translation of that access still uses the entry as it was before the edge.
- R9: clr_ref=1 clears the referenced bit of every entry at the next edge, except an entry accessed in that same cycle, which ends with the bit set.
- R10: Reset leaves every entry absent with frame 0 and referenced and modified bits 0, and both response flags at 0.
- R11: The inspection outputs show entry mon_idx without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 16 | Virtual address |
| req_write | input | 1 | Request is a store |
| ld_en | input | 1 | Load an entry |
| ld_idx | input | 4 | Entry to load |
| ld_frame | input | 3 | Frame value to load |
| ld_present | input | 1 | Present bit to load |
| ld_ref | input | 1 | Referenced bit to load |
| ld_mod | input | 1 | Modified bit to load |
| clr_ref | input | 1 | Clear every referenced bit |
| mon_idx | input | 4 | Entry to inspect |
| mon_frame | output | 3 | Frame of inspected entry |
| mon_present | output | 1 | Present bit of inspected entry |
| mon_ref | output | 1 | Referenced bit of inspected entry |
| mon_mod | output | 1 | Modified bit of inspected entry |
| rsp_valid | output | 1 | Translation succeeded |
| rsp_paddr | output | 15 | Physical address |
| rsp_fault | output | 1 | Page fault |

## Verification
On every cycle the assertions check that success and fault never coincide, that responses appear only one cycle after a request and never without one, that a successful address keeps the requested offset, and that a fault carries a zero address. Only the directed scenarios can show that the frame field comes from the right entry, that usage and dirty marks move as stated, that a same-cycle load beats a usage update, that the bulk clear spares a page touched in the same cycle, and that reset empties the whole table.

// File: rtl/pgxl_pkg.sv
package pgxl_pkg;
  localparam int FRAME_W = 3;

  typedef struct packed {
    logic               present;
    logic               referenced;
    logic               modified;
    logic [FRAME_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/pgxl_rst_sync.sv
module pgxl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/pgxl_entry.sv
module pgxl_entry
  import pgxl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_hit,
  input  pte_t ld_val,
  input  logic acc_hit,
  input  logic acc_write,
  input  logic clr_ref,
  output pte_t entry_q
);
  pte_t entry_d;
  logic entry_en;

  always_comb begin
    entry_en = ld_hit | acc_hit | clr_ref;
    entry_d  = entry_q;
    if (ld_hit) begin
      entry_d = ld_val;
    end else begin
      entry_d.referenced = (entry_q.referenced & ~clr_ref) | acc_hit;
      entry_d.modified   = entry_q.modified | (acc_hit & acc_write);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
    end else if (entry_en) begin
      entry_q <= entry_d;
    end
  end
endmodule

// File: rtl/pgxl_lookup.sv
module pgxl_lookup
  import pgxl_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 12,
  localparam int N     = 1 << PAGE_W,
  localparam int VA_W  = PAGE_W + OFF_W,
  localparam int PA_W  = FRAME_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_addr,
  input  pte_t [N-1:0]     tbl,
  output logic [PAGE_W-1:0] page_idx,
  output logic             acc_ok,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);
  pte_t            sel;
  logic [OFF_W-1:0] offset;
  logic            valid_d;
  logic            fault_d;
  logic [PA_W-1:0] paddr_d;

  always_comb begin
    page_idx = req_addr[VA_W-1:OFF_W];
    offset   = req_addr[OFF_W-1:0];
    sel      = tbl[page_idx];
    acc_ok   = req_valid & sel.present;
    valid_d  = acc_ok;
    fault_d  = req_valid & ~sel.present;
    paddr_d  = acc_ok ? {sel.frame, offset} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_fault <= fault_d;
      rsp_paddr <= paddr_d;
    end
  end
endmodule

// File: rtl/pgxl_translator.sv
module pgxl_translator
  import pgxl_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 12,
  localparam int N     = 1 << PAGE_W,
  localparam int VA_W  = PAGE_W + OFF_W,
  localparam int PA_W  = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_addr,
  input  logic               req_write,
  input  logic               ld_en,
  input  logic [PAGE_W-1:0]  ld_idx,
  input  logic [FRAME_W-1:0] ld_frame,
  input  logic               ld_present,
  input  logic               ld_ref,
  input  logic               ld_mod,
  input  logic               clr_ref,
  input  logic [PAGE_W-1:0]  mon_idx,
  output logic [FRAME_W-1:0] mon_frame,
  output logic               mon_present,
  output logic               mon_ref,
  output logic               mon_mod,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_fault
);
  logic            rst_int_n;
  pte_t [N-1:0]    tbl;
  pte_t            ld_val;
  pte_t            mon_sel;
  logic [PAGE_W-1:0] page_idx;
  logic            acc_ok;

  pgxl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    ld_val.present    = ld_present;
    ld_val.referenced = ld_ref;
    ld_val.modified   = ld_mod;
    ld_val.frame      = ld_frame;
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    pgxl_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .ld_hit    (ld_en && (ld_idx == PAGE_W'(i))),
      .ld_val    (ld_val),
      .acc_hit   (acc_ok && (page_idx == PAGE_W'(i))),
      .acc_write (req_write),
      .clr_ref   (clr_ref),
      .entry_q   (tbl[i])
    );
  end

  pgxl_lookup #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .tbl       (tbl),
    .page_idx  (page_idx),
    .acc_ok    (acc_ok),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
  );

  always_comb begin
    mon_sel     = tbl[mon_idx];
    mon_frame   = mon_sel.frame;
    mon_present = mon_sel.present;
    mon_ref     = mon_sel.referenced;
    mon_mod     = mon_sel.modified;
  end
endmodule

// File: rtl/pgxl_translator_chk.sv
module pgxl_translator_chk #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int PA_W  = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_addr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault
);
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_fault)); // R5

  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault)); // R3

  AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(rst_n)) |=> (rsp_valid || rsp_fault || !$past(rst_n, 2))); // R3

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_valid || rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))); // R2

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0)); // R5
endmodule

bind pgxl_translator pgxl_translator_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault)
);

// File: tb/pgxl_translator_tb.sv
module pgxl_translator_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_addr;
  logic        req_write;
  logic        ld_en;
  logic [3:0]  ld_idx;
  logic [2:0]  ld_frame;
  logic        ld_present;
  logic        ld_ref;
  logic        ld_mod;
  logic        clr_ref;
  logic [3:0]  mon_idx;
  logic [2:0]  mon_frame;
  logic        mon_present;
  logic        mon_ref;
  logic        mon_mod;
  logic        rsp_valid;
  logic [14:0] rsp_paddr;
  logic        rsp_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  pgxl_translator dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_frame(ld_frame),
    .ld_present(ld_present), .ld_ref(ld_ref), .ld_mod(ld_mod),
    .clr_ref(clr_ref), .mon_idx(mon_idx),
    .mon_frame(mon_frame), .mon_present(mon_present),
    .mon_ref(mon_ref), .mon_mod(mon_mod),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_addr = '0; req_write = 0;
    ld_en = 0; ld_idx = '0; ld_frame = '0; ld_present = 0;
    ld_ref = 0; ld_mod = 0; clr_ref = 0;
  endtask

  task automatic load(input int idx, input int frame, input bit pres);
    @(negedge clk);
    ld_en = 1; ld_idx = 4'(idx); ld_frame = 3'(frame);
    ld_present = pres; ld_ref = 0; ld_mod = 0;
    @(negedge clk);
    ld_en = 0;
  endtask

  // drive one request, sample its response one edge later
  task automatic access(input int addr, input bit wr);
    @(negedge clk);
    req_valid = 1; req_addr = 16'(addr); req_write = wr;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  function automatic int entry_word();
    return {mon_present, mon_ref, mon_mod, mon_frame};
  endfunction

  task automatic t_reset();
    for (int i = 0; i < 16; i++) begin
      mon_idx = 4'(i);
      #1;
      check("R10 entry cleared", entry_word(), 0);
    end
    check("R10 rsp_valid", rsp_valid, 0);
    check("R10 rsp_fault", rsp_fault, 0);
  endtask

  task automatic t_load();
    load(2, 6, 1);
    mon_idx = 4'd2; #1;
    check("R4 present", mon_present, 1);
    check("R11 frame", mon_frame, 6);
    @(negedge clk);
    ld_en = 1; ld_idx = 4'd11; ld_frame = 3'd5; ld_present = 1; ld_ref = 1; ld_mod = 1;
    @(negedge clk);
    ld_en = 0;
    mon_idx = 4'd11; #1;
    check("R4 all fields", entry_word(), {1'b1, 1'b1, 1'b1, 3'd5});
    load(11, 0, 0);
  endtask

  task automatic t_translate();
    access(8196, 0);
    check("R2 example addr", rsp_paddr, 24580);
    check("R2 valid", rsp_valid, 1);
    check("R5 no fault on hit", rsp_fault, 0);
    load(15, 7, 1);
    access(16'hFFFF, 0);
    check("R1 top page max offset", rsp_paddr, 15'h7FFF);
    load(0, 1, 1);
    access(16'h0ABC, 0);
    check("R1 page0 split", rsp_paddr, {3'd1, 12'hABC});
    @(negedge clk);
    check("R3 quiet after idle", {rsp_valid, rsp_fault}, 0);
  endtask

  task automatic t_fault();
    access(16'h9123, 1);
    check("R5 fault", rsp_fault, 1);
    check("R5 no valid", rsp_valid, 0);
    check("R5 zero addr", rsp_paddr, 0);
    mon_idx = 4'd9; #1;
    check("R6 fault leaves entry", entry_word(), 0);
  endtask

  task automatic t_refmod();
    load(4, 3, 1);
    access(16'h4010, 0);
    mon_idx = 4'd4; #1;
    check("R6 ref set on read", mon_ref, 1);
    check("R7 read keeps mod", mon_mod, 0);
    access(16'h4020, 1);
    mon_idx = 4'd4; #1;
    check("R7 mod set on write", mon_mod, 1);
    access(16'h4030, 0);
    mon_idx = 4'd4; #1;
    check("R7 mod sticky", mon_mod, 1);
  endtask

  task automatic t_priority();
    load(5, 3, 1);
    @(negedge clk);
    req_valid = 1; req_addr = 16'h5044; req_write = 1;
    ld_en = 1; ld_idx = 4'd5; ld_frame = 3'd1; ld_present = 1; ld_ref = 0; ld_mod = 0;
    @(negedge clk);
    req_valid = 0; req_write = 0; ld_en = 0;
    check("R8 response uses old frame", rsp_paddr, {3'd3, 12'h044});
    mon_idx = 4'd5; #1;
    check("R8 load wins", entry_word(), {1'b1, 1'b0, 1'b0, 3'd1});
  endtask

  task automatic t_clear();
    load(7, 2, 1);
    access(16'h2000, 0);
    access(16'h5000, 0);
    @(negedge clk);
    clr_ref = 1; req_valid = 1; req_addr = 16'h7008; req_write = 0;
    @(negedge clk);
    clr_ref = 0; req_valid = 0;
    mon_idx = 4'd2; #1; check("R9 page2 cleared", mon_ref, 0);
    mon_idx = 4'd5; #1; check("R9 page5 cleared", mon_ref, 0);
    mon_idx = 4'd4; #1; check("R9 page4 cleared", mon_ref, 0);
    mon_idx = 4'd4; #1; check("R9 mod untouched", mon_mod, 1);
    mon_idx = 4'd7; #1; check("R9 accessed page keeps ref", mon_ref, 1);
  endtask

  initial begin
    idle_inputs();
    mon_idx = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load();
    t_translate();
    t_fault();
    t_refmod();
    t_priority();
    t_clear();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule